// File: doc/BRIEF.md
# Linear CCD drive timing generator

This block generates the digital drive waveforms for a four-line linear colour CCD scanner sensor. It produces a shift-gate pulse, a complementary two-phase transfer clock pair, a reset-gate pulse, a clamp-gate pulse and the two colour/monochrome changeover levels. Every edge is placed by a parameter given in system-clock cycles. Parameter checks at elaboration reject values that break the sensor's minimum pulse widths and setup times or its allowed element-clock range for the stated clock frequency.

A line begins when a start request arrives while the block is idle. First a lead interval runs with the first transfer phase held active. Then comes the shift-gate pulse, then a trail interval, and then the readout. The readout has one element period per pixel and lasts 5490 elements in colour mode or 2745 in monochrome mode. The sensor's integration time is the spacing between successive shift-gate pulses, so the host sets it by when it issues start requests. The clamp scheme is either per-pixel (bit) or tied to the shift gate (line). The clamp selection and the colour/mono selection are both captured only when the shift gate rises.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are sh_o=0, phi1_o=1, phi2_o=0, rs_o=0, cp_o=0, busy_o=0, line_active_o=0, elem_idx_o=0, sw1_o=1 and sw2_o=0, which is colour mode with bit clamp.
- R2: A start_i sampled high while the block is idle is accepted at that clock edge. After that edge sh_o stays low for SH_LEAD cycles and then stays high for exactly SH_W cycles.
- R3: phi1_o is 1 and phi2_o is 0 in every cycle outside readout, which includes the SH_LEAD cycles before sh_o rises and the SH_TRAIL cycles after it falls.
- R4: Readout begins right after the trail interval and runs for LEN elements of ELEM_CYC cycles each. During readout line_active_o is 1, elem_idx_o counts 0 to LEN-1, phi1_o is 1 for the first ELEM_CYC/2 cycles of each element and phi2_o is its complement.
- R5: rs_o is 1 for the first RS_W cycles of every readout element and is 0 at all other times.
- R6: In bit clamp mode (clamp_line_i=0 when captured), cp_o is 1 in cycles RS_W to RS_W+CP_W-1 of every element, directly after the reset pulse, and is 0 outside readout.
- R7: In line clamp mode (clamp_line_i=1 when captured), cp_o equals sh_o in every cycle and is never 1 during readout.
- R8: A captured colour_i=1 gives sw1_o=1, sw2_o=0 and LEN=COLOR_LEN. A captured colour_i=0 gives sw1_o=0, sw2_o=1 and LEN=MONO_LEN.
- R9: colour_i and clamp_line_i are captured only at the clock edge where sh_o rises. During the lead interval the outputs keep the previous line's mode, and a change of these inputs during a line takes effect only at the next shift-gate pulse.
- R10: busy_o is 1 from the cycle after acceptance until the last cycle of the final element. A start_i seen while busy_o=1 has no effect, even in the final busy cycle, and a start_i in the first idle cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-line request |
| clamp_line_i | input | 1 | Clamp scheme: 0 per-pixel, 1 tied to shift gate |
| colour_i | input | 1 | 1 colour mode, 0 monochrome mode |
| sh_o | output | 1 | Shift-gate pulse |
| phi1_o | output | 1 | Transfer clock, first phase |
| phi2_o | output | 1 | Transfer clock, second phase |
| rs_o | output | 1 | Reset-gate pulse |
| cp_o | output | 1 | Clamp-gate pulse |
| sw1_o | output | 1 | Changeover level, high in colour mode |
| sw2_o | output | 1 | Changeover level, high in monochrome mode |
| busy_o | output | 1 | Line in progress |
| line_active_o | output | 1 | Readout in progress |
| elem_idx_o | output | IDX_W | Current element index during readout |

## Verification
Lines are run in each combination of colour/mono and bit/line clamp, and every output is compared cycle by cycle against a model built from the requirements. Moving from colour to mono and back shows whether the switch levels change at the shift-gate rise rather than at the request. Start requests placed in the lead interval, in mid-readout and in the final busy cycle check that a busy line is never restarted. Changing the mode inputs in mid-readout checks that the current line is left untouched and that the new mode is applied only at the following shift-gate pulse.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_SH    = 3'd2,
    PH_TRAIL = 3'd3,
    PH_READ  = 3'd4
  } phase_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
  import ccd_timer_pkg::*;
#(
  parameter int unsigned SH_LEAD  = 8,
  parameter int unsigned SH_W     = 40,
  parameter int unsigned SH_TRAIL = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   read_done_i,
  output phase_e phase_o,
  output logic   latch_o
);
  localparam int unsigned CNT_MAX = max3(SH_LEAD, SH_W, SH_TRAIL);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q;
  logic          seg_last;

  always_comb begin
    unique case (phase_q)
      PH_LEAD:  seg_last = (cnt_q == CW'(SH_LEAD - 1));
      PH_SH:    seg_last = (cnt_q == CW'(SH_W - 1));
      PH_TRAIL: seg_last = (cnt_q == CW'(SH_TRAIL - 1));
      default:  seg_last = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i)     phase_d = PH_LEAD;
      PH_LEAD:  if (seg_last)    phase_d = PH_SH;
      PH_SH:    if (seg_last)    phase_d = PH_TRAIL;
      PH_TRAIL: if (seg_last)    phase_d = PH_READ;
      PH_READ:  if (read_done_i) phase_d = PH_IDLE;
      default:                   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_d != phase_q)
        cnt_q <= '0;
      else if (phase_q inside {PH_LEAD, PH_SH, PH_TRAIL})
        cnt_q <= cnt_q + 1'b1;
      else
        cnt_q <= '0;
    end
  end

  // mode capture happens on the edge that enters the shift-gate phase
  assign latch_o = (phase_q == PH_LEAD) && seg_last;
  assign phase_o = phase_q;

  // R10
  lead_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LEAD && cnt_q == '0) |-> $past(phase_q) == PH_IDLE);

  // R2
  accept_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && start_i) |=> phase_q == PH_LEAD);
endmodule

// File: rtl/ccd_elem_gen.sv
module ccd_elem_gen #(
  parameter int unsigned ELEM_CYC = 8,
  parameter int unsigned RS_W     = 1,
  parameter int unsigned CP_W     = 1,
  parameter int unsigned IDX_W    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             phi1_o,
  output logic             rs_o,
  output logic             cp_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam int unsigned SW = $clog2(ELEM_CYC + 1);

  logic [SW-1:0]    sub_q;
  logic [IDX_W-1:0] idx_q;
  logic             sub_end;

  assign sub_end = (sub_q == SW'(ELEM_CYC - 1));
  assign done_o  = run_i && sub_end && (idx_q == last_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (!run_i) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (sub_end) begin
      sub_q <= '0;
      idx_q <= (idx_q == last_idx_i) ? '0 : idx_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign phi1_o = (sub_q < SW'(ELEM_CYC / 2));
  assign rs_o   = run_i && (sub_q < SW'(RS_W));
  assign cp_o   = run_i && (sub_q >= SW'(RS_W)) && (sub_q < SW'(RS_W + CP_W));
  assign idx_o  = idx_q;

  // R4
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> idx_q <= last_idx_i);

  // R5
  rs_at_phi1_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $rose(phi1_o)) |-> rs_o);
endmodule

// File: rtl/ccd_mode_hold.sv
module ccd_mode_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  input  logic colour_i,
  input  logic clamp_line_i,
  output logic colour_o,
  output logic clamp_line_o
);
  logic colour_q, clamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      colour_q <= 1'b1;
      clamp_q  <= 1'b0;
    end else if (latch_i) begin
      colour_q <= colour_i;
      clamp_q  <= clamp_line_i;
    end
  end

  assign colour_o     = colour_q;
  assign clamp_line_o = clamp_q;

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(latch_i) |-> ($stable(colour_q) && $stable(clamp_q)));
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 8,
  parameter int unsigned ELEM_CYC  = 8,
  parameter int unsigned RS_W      = 1,
  parameter int unsigned CP_W      = 1,
  parameter int unsigned SH_LEAD   = 8,
  parameter int unsigned SH_W      = 40,
  parameter int unsigned SH_TRAIL  = 8,
  parameter int unsigned COLOR_LEN = 5490,
  parameter int unsigned MONO_LEN  = 2745,
  localparam int unsigned MAX_LEN  = (COLOR_LEN > MONO_LEN) ? COLOR_LEN : MONO_LEN,
  localparam int unsigned IDX_W    = $clog2(MAX_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clamp_line_i,
  input  logic             colour_i,
  output logic             sh_o,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             rs_o,
  output logic             cp_o,
  output logic             sw1_o,
  output logic             sw2_o,
  output logic             busy_o,
  output logic             line_active_o,
  output logic [IDX_W-1:0] elem_idx_o
);
  // elaboration limits, times in ns, cycle time = 1000/CLK_MHZ ns
  if (SH_W * 1000 < 3000 * CLK_MHZ) begin : g_bad_sh_w
    $error("shift-gate width below 3000 ns");
  end
  if (SH_LEAD * 1000 < 120 * CLK_MHZ || SH_LEAD == 0) begin : g_bad_lead
    $error("phase-1 lead before shift gate below 120 ns");
  end
  if (SH_TRAIL * 1000 < 800 * CLK_MHZ || SH_TRAIL == 0) begin : g_bad_trail
    $error("phase-1 hold after shift gate below 800 ns");
  end
  if (CLK_MHZ * 1000 < 300 * ELEM_CYC || CLK_MHZ * 1000 > 10000 * ELEM_CYC) begin : g_bad_rate
    $error("element clock outside 0.3 to 10 MHz");
  end
  if (ELEM_CYC < 2 || RS_W == 0 || CP_W == 0 || RS_W + CP_W > ELEM_CYC) begin : g_bad_elem
    $error("reset and clamp pulses do not fit in one element");
  end
  if (MONO_LEN < 2 || COLOR_LEN < 2) begin : g_bad_len
    $error("line length too short");
  end

  phase_e           phase;
  logic             latch;
  logic             read_done;
  logic             colour_q, clamp_q;
  logic             reading;
  logic             e_phi1, e_rs, e_cp;
  logic [IDX_W-1:0] e_idx, last_idx;

  ccd_phase_seq #(
    .SH_LEAD (SH_LEAD),
    .SH_W    (SH_W),
    .SH_TRAIL(SH_TRAIL)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .read_done_i(read_done),
    .phase_o    (phase),
    .latch_o    (latch)
  );

  ccd_mode_hold u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch),
    .colour_i    (colour_i),
    .clamp_line_i(clamp_line_i),
    .colour_o    (colour_q),
    .clamp_line_o(clamp_q)
  );

  assign reading  = (phase == PH_READ);
  assign last_idx = colour_q ? IDX_W'(COLOR_LEN - 1) : IDX_W'(MONO_LEN - 1);

  ccd_elem_gen #(
    .ELEM_CYC(ELEM_CYC),
    .RS_W    (RS_W),
    .CP_W    (CP_W),
    .IDX_W   (IDX_W)
  ) u_elem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (reading),
    .last_idx_i(last_idx),
    .phi1_o    (e_phi1),
    .rs_o      (e_rs),
    .cp_o      (e_cp),
    .idx_o     (e_idx),
    .done_o    (read_done)
  );

  // all outputs decode registered state only; no input reaches an output combinationally
  assign sh_o          = (phase == PH_SH);
  assign phi1_o        = reading ? e_phi1 : 1'b1;
  assign phi2_o        = ~phi1_o;
  assign rs_o          = e_rs;
  assign cp_o          = clamp_q ? sh_o : e_cp;
  assign sw1_o         = colour_q;
  assign sw2_o         = ~colour_q;
  assign busy_o        = (phase != PH_IDLE);
  assign line_active_o = reading;
  assign elem_idx_o    = e_idx;

  // R3
  phi1_during_sh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_o |-> (phi1_o && !line_active_o));

  // R3
  trail_after_sh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sh_o) |-> (!line_active_o && phi1_o));

  // R6
  cp_after_rs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cp_o) && !clamp_q) |-> $past(rs_o));

  // R7
  line_cp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_q && line_active_o) |-> !cp_o);

  // R8
  line_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_active_o) |->
      $past(elem_idx_o) == (colour_q ? IDX_W'(COLOR_LEN - 1) : IDX_W'(MONO_LEN - 1)));

  // R9
  sw_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_active_o |-> ($stable(sw1_o) && $stable(sw2_o)));

  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(line_active_o));
endmodule

// File: tb/tb_ccd_line_timer.sv
module tb_ccd_line_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 8;
  localparam int E          = 8;
  localparam int RSW        = 1;
  localparam int CPW        = 1;
  localparam int L          = 2;
  localparam int W          = 24;
  localparam int T          = 7;
  localparam int CL         = 12;
  localparam int ML         = 6;
  localparam int IDX_W      = $clog2(CL);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, clamp_line_i = 1'b0, colour_i = 1'b1;
  logic sh_o, phi1_o, phi2_o, rs_o, cp_o, sw1_o, sw2_o, busy_o, line_active_o;
  logic [IDX_W-1:0] elem_idx_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_line_timer #(
    .CLK_MHZ(CLK_MHZ), .ELEM_CYC(E), .RS_W(RSW), .CP_W(CPW),
    .SH_LEAD(L), .SH_W(W), .SH_TRAIL(T), .COLOR_LEN(CL), .MONO_LEN(ML)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clamp_line_i(clamp_line_i),
    .colour_i(colour_i), .sh_o(sh_o), .phi1_o(phi1_o), .phi2_o(phi2_o), .rs_o(rs_o),
    .cp_o(cp_o), .sw1_o(sw1_o), .sw2_o(sw2_o), .busy_o(busy_o),
    .line_active_o(line_active_o), .elem_idx_o(elem_idx_o)
  );

  typedef struct {
    bit sh, phi1, phi2, rs, cp, sw1, sw2, busy, act, rd, lead, clm;
    int idx;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   cur_col = 1'b1;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic exp_t mk(int k, bit col_old, bit col, bit clm);
    exp_t e;
    int len, b, r, s;
    len = col ? CL : ML;
    b   = L + W + T + len * E;
    e.clm = clm; e.lead = (k < L); e.rd = 1'b0;
    e.sh = 0; e.phi1 = 1; e.phi2 = 0; e.rs = 0; e.cp = 0; e.act = 0; e.idx = 0;
    e.busy = (k < b);
    e.sw1 = (k < L) ? col_old : col;
    e.sw2 = ~e.sw1;
    if (k >= L && k < L + W) begin
      e.sh = 1;
      e.cp = clm;
    end else if (k >= L + W + T && k < b) begin
      r = k - (L + W + T);
      s = r % E;
      e.rd = 1; e.act = 1; e.idx = r / E;
      e.phi1 = (s < E / 2); e.phi2 = ~e.phi1;
      e.rs = (s < RSW);
      e.cp = clm ? 1'b0 : (s >= RSW && s < RSW + CPW);
    end
    return e;
  endfunction

  // monitor: pops one expected item per cycle, samples mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin : pop
        exp_t e;
        e = exp_q.pop_front();
        chk("R2", "sh", int'(sh_o), int'(e.sh));
        chk(e.rd ? "R4" : "R3", "phi1", int'(phi1_o), int'(e.phi1));
        chk(e.rd ? "R4" : "R3", "phi2", int'(phi2_o), int'(e.phi2));
        chk("R5", "rs", int'(rs_o), int'(e.rs));
        chk(e.clm ? "R7" : "R6", "cp", int'(cp_o), int'(e.cp));
        chk(e.lead ? "R9" : "R8", "sw1", int'(sw1_o), int'(e.sw1));
        chk(e.lead ? "R9" : "R8", "sw2", int'(sw2_o), int'(e.sw2));
        chk("R10", "busy", int'(busy_o), int'(e.busy));
        chk("R4", "active", int'(line_active_o), int'(e.act));
        chk("R4", "idx", int'(elem_idx_o), e.idx);
      end
    end
  end

  // driver: requests a line, predicts every cycle, optionally pokes start and flips modes
  task automatic run_line(input bit col, input bit clm, input int poke, input bit flip);
    int b;
    b = L + W + T + (col ? CL : ML) * E;
    @(negedge clk);
    colour_i = col; clamp_line_i = clm; start_i = 1'b1;
    @(posedge clk);
    #1;
    for (int k = 0; k <= b; k++) exp_q.push_back(mk(k, cur_col, col, clm));
    cur_col = col;
    for (int i = 0; i <= b; i++) begin
      @(negedge clk);
      start_i = (i == poke);
      if (flip && i == poke) begin
        colour_i = ~col;
        clamp_line_i = ~clm;
      end
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "sh", int'(sh_o), 0);
    chk("R1", "phi1", int'(phi1_o), 1);
    chk("R1", "phi2", int'(phi2_o), 0);
    chk("R1", "rs", int'(rs_o), 0);
    chk("R1", "cp", int'(cp_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "sw1", int'(sw1_o), 1);
    chk("R1", "sw2", int'(sw2_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 after release
    chk("R1", "active", int'(line_active_o), 0);
    chk("R1", "idx", int'(elem_idx_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    // R10 start in final busy cycle must be ignored
    run_line(1'b1, 1'b0, L + W + T + CL * E - 1, 1'b0);
    // R9 mode inputs flipped mid-readout, start poked mid-readout
    run_line(1'b0, 1'b1, L + W + T + 5, 1'b1);
    // R8 back to colour; lead interval still shows mono (R9)
    run_line(1'b1, 1'b0, -1, 1'b0);
    // R10 start poked during lead
    run_line(1'b0, 1'b0, 0, 1'b0);
    // R7 colour with line clamp
    run_line(1'b1, 1'b1, -1, 1'b0);
    repeat (3) @(negedge clk);
    // R10 idle stays idle
    chk("R10", "busy idle", int'(busy_o), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule